// File: doc/BRIEF.md
# TCM Wait-State Access Controller

This block connects a processor's tightly coupled memory port to a synchronous single-port SRAM macro. Each access finishes in one of two timings. In the one-cycle timing the request is accepted in the cycle it is raised. In the two-cycle timing the macro gets an extra cycle, for use when the core clock is too fast for a single-cycle path. Reads and writes each have their own timing selector, so the two directions can run at different speeds. A further control keeps the macro's clock-gate enable high at all times.

The processor raises `cpu_req` together with direction, address and write data, and keeps them steady until `cpu_ready` is high. Read data always appears on `cpu_rdata` in the cycle after the one in which `cpu_ready` was high, for both timings. The timing selectors are registered inside the block. A new setting applies to requests that begin in any cycle after the pins change. An access that has already started in two-cycle timing always finishes in two cycles.

Top module: `tcm_wait_ctrl`

## Requirements
- R1: After reset, both directions use the one-cycle timing, even when the selector pins are high during reset. In one-cycle timing `cpu_ready` and `mem_ce` are high in the same cycle as `cpu_req`. Address, write data and direction pass straight to the macro.
- R2: For a one-cycle read, `cpu_rdata` shows the macro's read result in the cycle after the ready cycle.
- R3: When `cfg_rd_wait` is 1, a read takes two cycles. In the first cycle `mem_ce` is 1 and `cpu_ready` is 0. In the second cycle `cpu_ready` is 1 and `mem_ce` is 0.
- R4: When `cfg_wr_wait` is 1, a write takes two cycles. `mem_we`, `mem_addr` and `mem_wdata` keep their first-cycle values through the second cycle, even if the CPU-side inputs change.
- R5: The read selector has no effect on write timing, and the write selector has no effect on read timing.
- R6: For a two-cycle read, the macro output is captured at the end of the second cycle. It is shown on `cpu_rdata` from the next cycle until the next completed access.
- R7: A selector change seen during the first cycle of a two-cycle access does not shorten that access. A change made in the same cycle as a request does not affect that request.
- R8: When `cfg_force_clk` is 1, `mem_clk_en` is 1. When it is 0, `mem_clk_en` is 1 only in cycles with a request or a two-cycle access in flight.
- R9: A new request raised in the cycle right after a ready cycle is accepted without an idle gap, in either timing.
- R10: Asserting `rst_n` during a two-cycle access drops `mem_ce` and `cpu_ready` at once. After reset is released, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised inside the block |
| cfg_rd_wait | input | 1 | 1 selects two-cycle reads |
| cfg_wr_wait | input | 1 | 1 selects two-cycle writes |
| cfg_force_clk | input | 1 | 1 holds the macro clock-gate enable high |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | DW | Read data, valid in the cycle after ready |
| mem_ce | output | 1 | Macro chip enable, high for one cycle per access |
| mem_we | output | 1 | Macro write enable |
| mem_addr | output | AW | Macro address |
| mem_wdata | output | DW | Macro write data |
| mem_rdata | input | DW | Macro read data, one cycle after chip enable |
| mem_clk_en | output | 1 | Macro clock-gate enable |

## Verification
A phase register stuck in its second state shows up within one cycle: either `cpu_ready` is high with no request, or a second access never asserts `mem_ce`. A wrong captured direction or address shows up on the next macro access or read-back. Wrong data in the read-capture register or its select flag shows up as a wrong `cpu_rdata` value in the cycle after ready. A mode register that does not reset, or that loads at the wrong time, shows up as a wrong ready cycle on the very first request after reset or after a selector change.

// File: rtl/tcm_wait_pkg.sv
package tcm_wait_pkg;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_SECOND = 1'b1
  } tcm_phase_e;

  typedef struct packed {
    logic rd_slow;
    logic wr_slow;
  } tcm_mode_t;

  function automatic logic pick_slow(input tcm_mode_t m, input logic is_write);
    return is_write ? m.wr_slow : m.rd_slow;
  endfunction

endpackage

// File: rtl/tcm_rst_sync.sv
module tcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tcm_phase_fsm.sv
module tcm_phase_fsm
  import tcm_wait_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rd_wait,
  input  logic cfg_wr_wait,
  input  logic cpu_req,
  input  logic cpu_we,
  output logic issue,
  output logic ready,
  output logic start_slow,
  output logic busy,
  output logic held_we,
  output logic slow_rd_done
);
  tcm_phase_e phase_q, phase_d;
  tcm_mode_t  mode_q, mode_d;
  logic       held_we_q, held_we_d;
  logic       slow_sel;

  // mode registers: reset to one-cycle timing, loaded every cycle
  always_comb begin
    mode_d.rd_slow = cfg_rd_wait;
    mode_d.wr_slow = cfg_wr_wait;
  end

  always_comb begin
    slow_sel   = pick_slow(mode_q, cpu_we);
    issue      = 1'b0;
    ready      = 1'b0;
    start_slow = 1'b0;
    phase_d    = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        issue      = cpu_req;
        ready      = cpu_req & ~slow_sel;
        start_slow = cpu_req & slow_sel;
        if (start_slow) phase_d = PH_SECOND;
      end
      PH_SECOND: begin
        ready   = 1'b1;
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    held_we_d = start_slow ? cpu_we : held_we_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      mode_q    <= '0;
      held_we_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      mode_q    <= mode_d;
      held_we_q <= held_we_d;
    end
  end

  assign busy         = (phase_q == PH_SECOND);
  assign held_we      = held_we_q;
  assign slow_rd_done = busy & ~held_we_q;

  // R3: the second phase never lasts longer than one cycle
  a_r3_second_is_single: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SECOND) |=> (phase_q == PH_IDLE));

  // R7: the direction of an access in flight is frozen
  a_r7_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    start_slow |=> (held_we_q == $past(cpu_we)));
endmodule

// File: rtl/tcm_req_hold.sv
module tcm_req_hold #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          busy,
  input  logic          held_we,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    addr_d = capture ? cpu_addr  : addr_q;
    data_d = capture ? cpu_wdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    if (busy) begin
      mem_we    = held_we;
      mem_addr  = addr_q;
      mem_wdata = data_q;
    end else begin
      mem_we    = cpu_req & cpu_we;
      mem_addr  = cpu_addr;
      mem_wdata = cpu_wdata;
    end
  end

  // R4: the macro sees the same access in both cycles of a two-cycle access
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
endmodule

// File: rtl/tcm_rdata_stage.sv
module tcm_rdata_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          slow_rd_done,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cpu_rdata
);
  logic [DW-1:0] rdata_q, rdata_d;
  logic          sel_q, sel_d;

  always_comb begin
    rdata_d = slow_rd_done ? mem_rdata : rdata_q;
    sel_d   = ready ? slow_rd_done : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      sel_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      sel_q   <= sel_d;
    end
  end

  assign cpu_rdata = sel_q ? rdata_q : mem_rdata;

  // R6: captured read data stays put until another access completes
  a_r6_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !ready) |=> ($stable(sel_q) && $stable(cpu_rdata)));
endmodule

// File: rtl/tcm_wait_ctrl.sv
module tcm_wait_ctrl #(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rd_wait,
  input  logic          cfg_wr_wait,
  input  logic          cfg_force_clk,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_ce,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_clk_en
);
  logic rst_i;
  logic issue, start_slow, busy, held_we, slow_rd_done;

  tcm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i)
  );

  tcm_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_i),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
    .cpu_req(cpu_req), .cpu_we(cpu_we),
    .issue(issue), .ready(cpu_ready), .start_slow(start_slow),
    .busy(busy), .held_we(held_we), .slow_rd_done(slow_rd_done)
  );

  tcm_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_i),
    .capture(start_slow), .busy(busy), .held_we(held_we),
    .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  tcm_rdata_stage #(.DW(DW)) u_rdata (
    .clk(clk), .rst_n(rst_i),
    .ready(cpu_ready), .slow_rd_done(slow_rd_done),
    .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata)
  );

  assign mem_ce = issue;

  always_comb begin
    mem_clk_en = cfg_force_clk | cpu_req | busy;
  end

  // R1: a request meeting one-cycle timing completes in its own cycle
  a_r1_fast_same_cycle: assert property (@(posedge clk) disable iff (!rst_i)
    (cpu_req && !busy && !(cpu_we ? $past(cfg_wr_wait) : $past(cfg_rd_wait)))
      |-> (cpu_ready && mem_ce));

  // R3: an enable without ready is followed by ready without enable
  a_r3_wait_two_cycles: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_ce && !cpu_ready) |=> (cpu_ready && !mem_ce));

  // R8: clock-gate enable covers forced operation and every request
  a_r8_force_on: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_force_clk |-> mem_clk_en);
  a_r8_req_on: assert property (@(posedge clk) disable iff (!rst_i)
    cpu_req |-> mem_clk_en);
endmodule

// File: tb/tcm_wait_ctrl_tb.sv
`timescale 1ns/1ps
module tcm_wait_ctrl_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NV = 12;

  // entry: [14] write, [13] read-slow, [12] write-slow, [11:8] addr, [7:0] data
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'h1, 8'h11},
    {1'b1, 1'b0, 1'b1, 4'h2, 8'h22},
    {1'b0, 1'b0, 1'b0, 4'h1, 8'h00},
    {1'b0, 1'b1, 1'b0, 4'h2, 8'h00},
    {1'b1, 1'b1, 1'b0, 4'h3, 8'h33},
    {1'b0, 1'b1, 1'b0, 4'h3, 8'h00},
    {1'b1, 1'b0, 1'b1, 4'h4, 8'h44},
    {1'b0, 1'b0, 1'b1, 4'h4, 8'h00},
    {1'b1, 1'b1, 1'b1, 4'h5, 8'h55},
    {1'b0, 1'b1, 1'b1, 4'h5, 8'h00},
    {1'b1, 1'b0, 1'b0, 4'h2, 8'hA5},
    {1'b0, 1'b0, 1'b1, 4'h2, 8'h00}
  };

  logic          clk, rst_n;
  logic          cfg_rd_wait, cfg_wr_wait, cfg_force_clk;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          mem_ce, mem_we, mem_clk_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] sram    [16];
  logic [DW-1:0] ref_mem [16];
  int n_checks = 0;
  int n_errors = 0;

  tcm_wait_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait), .cfg_force_clk(cfg_force_clk),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_clk_en(mem_clk_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // synchronous SRAM model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_ce) begin
      if (mem_we) sram[mem_addr] <= mem_wdata;
      else        mem_rdata      <= sram[mem_addr];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic rdw, input logic wrw,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    int cyc;
    int exp_cyc;
    @(negedge clk);
    cfg_rd_wait = rdw; cfg_wr_wait = wrw;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    check("R1 enable in first cycle", mem_ce, 1'b1);
    if (we) ref_mem[a] = d;
    exp_cyc = we ? (wrw ? 2 : 1) : (rdw ? 2 : 1);
    cyc = 1;
    while (!cpu_ready && cyc < 4) begin
      @(negedge clk); #1; cyc++;
    end
    if (exp_cyc == 1) check("R1 R5 one-cycle latency", cyc, exp_cyc);
    else              check("R3 R4 R5 two-cycle latency", cyc, exp_cyc);
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    if (!we) begin
      if (rdw) check("R6 slow read data", cpu_rdata, ref_mem[a]);
      else     check("R2 fast read data", cpu_rdata, ref_mem[a]);
    end
  endtask

  task automatic do_reset(input logic rdw, input logic wrw);
    @(negedge clk);
    rst_n = 1'b0; cpu_req = 1'b0; cfg_rd_wait = rdw; cfg_wr_wait = wrw;
    #1;
    check("R10 ready drops in reset", cpu_ready, 1'b0);
    check("R10 enable drops in reset", mem_ce, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    cfg_rd_wait = 1'b1; cfg_wr_wait = 1'b1; cfg_force_clk = 1'b0;
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R1: selector pins high through reset, first request still one cycle
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 4'h0; cpu_wdata = 8'h0F;
    ref_mem[0] = 8'h0F;
    #1;
    check("R1 reset default fast", cpu_ready, 1'b1);
    check("R8 clk enable on request", mem_clk_en, 1'b1);
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    check("R10 idle after reset", cpu_ready, 1'b0);
    check("R8 clk enable idle", mem_clk_en, 1'b0);
    check("R1 no write when idle", mem_we, 1'b0);
    cfg_force_clk = 1'b1;
    #1;
    check("R8 clk enable forced", mem_clk_en, 1'b1);
    cfg_force_clk = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:0]);
    end

    // R4: inputs change in the second cycle, macro sees the first-cycle values
    @(negedge clk); cfg_wr_wait = 1'b1; cfg_rd_wait = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 4'h6; cpu_wdata = 8'h66;
    ref_mem[6] = 8'h66;
    #1;
    check("R3 no ready in first cycle", cpu_ready, 1'b0);
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 4'h7; cpu_wdata = 8'h77;
    #1;
    check("R4 held address", mem_addr, 4'h6);
    check("R4 held data", mem_wdata, 8'h66);
    check("R4 held write enable", mem_we, 1'b1);
    check("R3 ready in second cycle", cpu_ready, 1'b1);
    check("R3 no enable in second cycle", mem_ce, 1'b0);
    @(negedge clk); cpu_req = 1'b0;
    access(1'b0, 1'b0, 1'b1, 4'h6, 8'h00);

    // R7: selector dropped during the first cycle of a slow read
    @(negedge clk); cfg_rd_wait = 1'b1;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 4'h1;
    #1;
    check("R7 slow read first cycle", cpu_ready, 1'b0);
    cfg_rd_wait = 1'b0;
    @(negedge clk); #1;
    check("R7 access not shortened", cpu_ready, 1'b1);
    @(negedge clk);
    cpu_addr = 4'h3; cfg_rd_wait = 1'b1;
    #1;
    check("R6 R9 slow data with next request", cpu_rdata, ref_mem[1]);
    check("R7 change in request cycle ignored", cpu_ready, 1'b1);
    @(negedge clk); cpu_req = 1'b0;
    #1;
    check("R2 fast read data", cpu_rdata, ref_mem[3]);

    // R9: back-to-back slow reads
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 4'h4;
    @(negedge clk); #1;
    check("R9 first slow ready", cpu_ready, 1'b1);
    @(negedge clk);
    cpu_addr = 4'h5;
    #1;
    check("R9 second request accepted", mem_ce, 1'b1);
    check("R6 data during next access", cpu_rdata, ref_mem[4]);
    @(negedge clk); #1;
    check("R6 data held until next completion", cpu_rdata, ref_mem[4]);
    @(negedge clk); cpu_req = 1'b0;
    #1;
    check("R6 second slow data", cpu_rdata, ref_mem[5]);

    // R10: reset in the middle of a slow read
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 4'h2;
    do_reset(1'b0, 1'b0);
    @(negedge clk); #1;
    check("R10 idle after mid-access reset", cpu_ready, 1'b0);
    access(1'b0, 1'b0, 1'b0, 4'h2, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule